// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic core of a small byte-wide accumulator machine. It holds the accumulator and a flags byte. On each cycle where the operation strobe is high, it carries out the selected operation. A two-operand operation combines the accumulator with an operand byte: add, add with carry, subtract, subtract with borrow, AND, OR, XOR and compare. There are also four rotate forms. The result goes back into the accumulator, except for compare, which only sets flags.

A separate unary path takes a byte from the register file and always presents that byte plus one or minus one on its own output. An external register file or memory can write that value to any destination. When an increment or decrement is strobed, the flags follow the unary result and the accumulator is left alone.

The flags byte packs sign, zero, half carry, even parity and carry at fixed bit positions. It can be pushed to memory and restored as a unit. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `acc_alu_core`

## Requirements
- R1: For as long as reset is held low and for two clocks after it rises, the accumulator reads 0x00 and the flags byte reads 0x02.
- R2: Opcode 0 (add) and opcode 1 (add with carry, using the current carry flag as carry-in) write A+B(+c) modulo 256 to the accumulator. Carry is set by a carry out of bit 7. Half carry is set by a carry from bit 3 into bit 4.
- R3: Opcode 2 (subtract) and opcode 3 (subtract with borrow, taking the carry flag as borrow-in) write A-B(-c) modulo 256 to the accumulator. Carry is set when the full difference needs a borrow. Half carry is set when the low nibble needs a borrow.
- R4: Opcode 7 (compare) sets every flag exactly as opcode 2 would and leaves the accumulator unchanged.
- R5: Opcode 4 (AND), opcode 5 (XOR) and opcode 6 (OR) write the bitwise result to the accumulator and clear both carry and half carry.
- R6: After every arithmetic, logic, compare, increment or decrement operation, sign equals bit 7 of the result. Zero is set when all result bits are 0. Parity is set when the result holds an even number of ones.
- R7: The four rotates change the accumulator and carry, and leave all other flags unchanged:
  - opcode 8 rotates left with bit 7 into bit 0 and into carry;
  - opcode 9 rotates right with bit 0 into bit 7 and into carry;
  - opcode 10 rotates left through carry (old carry into bit 0, bit 7 into carry);
  - opcode 11 rotates right through carry (old carry into bit 7, bit 0 into carry).
- R8: The unary output always shows the register byte minus one when the opcode is 13, and the register byte plus one otherwise, modulo 256.
- R9: A strobed opcode 12 (increment) or 13 (decrement) updates sign, zero, parity and half carry from the unary result. Half carry is set on a low-nibble carry for increment and on a low-nibble borrow for decrement. Carry and the accumulator are unchanged.
- R10: The flags byte layout is sign at bit 7, zero at bit 6, half carry at bit 4, parity at bit 2 and carry at bit 0. Bit 1 always reads 1, and bits 5 and 3 always read 0.
- R11: With the strobe low, or with opcode 14 or 15, neither the accumulator nor the flags change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_strobe | input | 1 | Performs the operation on this clock edge |
| op_code | input | 4 | Operation select |
| operand | input | 8 | Second operand for two-operand operations |
| reg_byte | input | 8 | Register-file byte for the unary path |
| acc | output | 8 | Accumulator |
| unary_out | output | 8 | Combinational increment/decrement of reg_byte |
| flags | output | 8 | Packed status flags |

## Verification
The bench drives the carry and borrow boundaries. These include a sum that wraps to exactly zero with both carries set, a subtract that underflows to 0xFF, and a subtract-with-borrow that borrows only in the low nibble. A design that takes the carry from the wrong bit, or inverts the borrow sense, shows a wrong carry or half carry there.

Compare with equal and unequal operands catches a design that writes the difference into the accumulator. Increment of 0xFF and decrement of 0x00 with carry already set catch a unary path that clobbers carry or misplaces its half carry.

The rotates are run through carry in both directions, with the other flags non-zero. That catches a design that mixes up the circular and through-carry forms or disturbs sign, zero or parity. A long pseudo-random run then compares every step against a reference model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_CMP  = 4'd7,
    OP_RLC  = 4'd8,
    OP_RRC  = 4'd9,
    OP_RAL  = 4'd10,
    OP_RAR  = 4'd11,
    OP_INC  = 4'd12,
    OP_DEC  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flag_set_t;

  localparam flag_set_t FLAGS_RESET = '{s: 1'b0, z: 1'b0, ac: 1'b0, p: 1'b0, cy: 1'b0};

  // Packed layout: S Z 0 AC 0 P 1 CY
  function automatic logic [7:0] pack_flags(input flag_set_t f);
    return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
  endfunction

endpackage

// File: rtl/acc_alu_rstsync.sv
module acc_alu_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/acc_alu_szp.sv
module acc_alu_szp #(
  parameter int W = 8
) (
  input  logic [W-1:0] value,
  output logic         sign,
  output logic         zero,
  output logic         even
);

  always_comb begin
    sign = value[W-1];
    zero = (value == '0);
    even = ~^value;
  end

endmodule

// File: rtl/acc_alu_twoop.sv
module acc_alu_twoop
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cy_in,
  output logic [W-1:0] res,
  output logic         cy_out,
  output logic         ac_out,
  output logic         acc_we,
  output logic         szpa_we,
  output logic         hit
);

  localparam int H = W / 2;

  logic         cin;
  logic [W:0]   add_full;
  logic [H:0]   add_half;
  logic [W:0]   sub_full;
  logic [H:0]   sub_half;

  always_comb begin
    cin      = ((op == OP_ADC) || (op == OP_SBB)) ? cy_in : 1'b0;
    add_full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    add_half = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
    sub_full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    sub_half = {1'b0, a[H-1:0]} - {1'b0, b[H-1:0]} - {{H{1'b0}}, cin};
  end

  always_comb begin
    res     = a;
    cy_out  = cy_in;
    ac_out  = 1'b0;
    acc_we  = 1'b0;
    szpa_we = 1'b0;
    hit     = 1'b1;
    case (op)
      OP_ADD, OP_ADC: begin
        res = add_full[W-1:0]; cy_out = add_full[W]; ac_out = add_half[H];
        acc_we = 1'b1; szpa_we = 1'b1;
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        res = sub_full[W-1:0]; cy_out = sub_full[W]; ac_out = sub_half[H];
        acc_we = (op != OP_CMP); szpa_we = 1'b1;
      end
      OP_AND: begin res = a & b; cy_out = 1'b0; acc_we = 1'b1; szpa_we = 1'b1; end
      OP_XOR: begin res = a ^ b; cy_out = 1'b0; acc_we = 1'b1; szpa_we = 1'b1; end
      OP_OR:  begin res = a | b; cy_out = 1'b0; acc_we = 1'b1; szpa_we = 1'b1; end
      OP_RLC: begin res = {a[W-2:0], a[W-1]}; cy_out = a[W-1]; acc_we = 1'b1; end
      OP_RRC: begin res = {a[0], a[W-1:1]};   cy_out = a[0];   acc_we = 1'b1; end
      OP_RAL: begin res = {a[W-2:0], cy_in};  cy_out = a[W-1]; acc_we = 1'b1; end
      OP_RAR: begin res = {cy_in, a[W-1:1]};  cy_out = a[0];   acc_we = 1'b1; end
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_alu_unary.sv
module acc_alu_unary #(
  parameter int W = 8
) (
  input  logic [W-1:0] src,
  input  logic         down,
  output logic [W-1:0] res,
  output logic         ac
);

  localparam int H = W / 2;

  always_comb begin
    if (down) begin
      res = src - {{(W-1){1'b0}}, 1'b1};
      ac  = (src[H-1:0] == '0);
    end else begin
      res = src + {{(W-1){1'b0}}, 1'b1};
      ac  = (src[H-1:0] == {H{1'b1}});
    end
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_strobe,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] reg_byte,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] unary_out,
  output logic [7:0]        flags
);

  alu_op_e           op;
  logic              rst_q_n;
  logic [DATA_W-1:0] acc_q, acc_d;
  flag_set_t         flg_q, flg_d;

  logic [DATA_W-1:0] bin_res;
  logic              bin_cy, bin_ac, bin_acc_we, bin_szpa_we, bin_hit;
  logic              un_ac, is_unary;
  logic              b_s, b_z, b_p, u_s, u_z, u_p;

  assign op = alu_op_e'(op_code);

  acc_alu_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  acc_alu_twoop #(.W(DATA_W)) u_twoop (
    .op(op), .a(acc_q), .b(operand), .cy_in(flg_q.cy),
    .res(bin_res), .cy_out(bin_cy), .ac_out(bin_ac),
    .acc_we(bin_acc_we), .szpa_we(bin_szpa_we), .hit(bin_hit)
  );

  acc_alu_unary #(.W(DATA_W)) u_unary (
    .src(reg_byte), .down(op == OP_DEC), .res(unary_out), .ac(un_ac)
  );

  acc_alu_szp #(.W(DATA_W)) u_szp_bin (
    .value(bin_res), .sign(b_s), .zero(b_z), .even(b_p)
  );

  acc_alu_szp #(.W(DATA_W)) u_szp_un (
    .value(unary_out), .sign(u_s), .zero(u_z), .even(u_p)
  );

  assign is_unary = (op == OP_INC) || (op == OP_DEC);

  // Next-state
  always_comb begin
    acc_d = acc_q;
    flg_d = flg_q;
    if (is_unary) begin
      flg_d.s  = u_s;
      flg_d.z  = u_z;
      flg_d.p  = u_p;
      flg_d.ac = un_ac;
    end else if (bin_hit) begin
      flg_d.cy = bin_cy;
      if (bin_szpa_we) begin
        flg_d.s  = b_s;
        flg_d.z  = b_z;
        flg_d.p  = b_p;
        flg_d.ac = bin_ac;
      end
      if (bin_acc_we) acc_d = bin_res;
    end
  end

  // Registers with clock enable
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      acc_q <= '0;
      flg_q <= FLAGS_RESET;
    end else if (op_strobe) begin
      acc_q <= acc_d;
      flg_q <= flg_d;
    end
  end

  assign acc   = acc_q;
  assign flags = pack_flags(flg_q);

  AST_CMP_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_strobe && op_code == 4'd7) |=> $stable(acc)); // R4

  AST_LOGIC_CLEARS_CY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_strobe && (op_code == 4'd4 || op_code == 4'd5 || op_code == 4'd6))
      |=> (flags[0] == 1'b0 && flags[4] == 1'b0)); // R5

  AST_ROT_ONLY_CY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_strobe && op_code >= 4'd8 && op_code <= 4'd11)
      |=> (flags[7:1] == $past(flags[7:1]))); // R7

  AST_UNARY_KEEPS_CY_ACC: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_strobe && (op_code == 4'd12 || op_code == 4'd13))
      |=> (flags[0] == $past(flags[0]) && $stable(acc))); // R9

  AST_FIXED_FLAG_BITS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flags[1] == 1'b1 && flags[5] == 1'b0 && flags[3] == 1'b0)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!op_strobe || op_code == 4'd14 || op_code == 4'd15)
      |=> ($stable(acc) && $stable(flags))); // R11

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_strobe && op_code <= 4'd6) |=> (flags[6] == (acc == '0))); // R6

endmodule

// File: tb/acc_alu_core_test.sv
module acc_alu_core_test;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       op_strobe;
  logic [3:0] op_code;
  logic [7:0] operand;
  logic [7:0] reg_byte;
  logic [7:0] acc;
  logic [7:0] unary_out;
  logic [7:0] flags;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [7:0] m_acc;
  logic       m_s, m_z, m_ac, m_p, m_cy;

  logic [15:0] q_val[$];
  string       q_tag[$];

  acc_alu_core uut (
    .clk(clk), .rst_n(rst_n), .op_strobe(op_strobe), .op_code(op_code),
    .operand(operand), .reg_byte(reg_byte), .acc(acc),
    .unary_out(unary_out), .flags(flags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mpack();
    return {m_s, m_z, 1'b0, m_ac, 1'b0, m_p, 1'b1, m_cy};
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic set_szp(input logic [7:0] v);
    m_s = v[7];
    m_z = (v == 8'h00);
    m_p = ~^v;
  endtask

  // Driver: drive one operation, check unary path, push expected state
  task automatic issue(input logic [3:0] op, input logic [7:0] b,
                       input logic [7:0] r, input logic stb, input string tag);
    logic [8:0] t;
    logic [4:0] h;
    logic [7:0] u;
    logic       c;
    @(negedge clk);
    op_strobe = stb;
    op_code   = op;
    operand   = b;
    reg_byte  = r;
    #1;
    u = (op == 4'd13) ? r - 8'd1 : r + 8'd1;
    check8({tag, " R8 unary"}, unary_out, u);
    if (stb) begin
      c = (op == 4'd1 || op == 4'd3) ? m_cy : 1'b0;
      case (op)
        4'd0, 4'd1: begin
          t = {1'b0, m_acc} + {1'b0, b} + {8'd0, c};
          h = {1'b0, m_acc[3:0]} + {1'b0, b[3:0]} + {4'd0, c};
          m_cy = t[8]; m_ac = h[4]; set_szp(t[7:0]); m_acc = t[7:0];
        end
        4'd2, 4'd3, 4'd7: begin
          t = {1'b0, m_acc} - {1'b0, b} - {8'd0, c};
          h = {1'b0, m_acc[3:0]} - {1'b0, b[3:0]} - {4'd0, c};
          m_cy = t[8]; m_ac = h[4]; set_szp(t[7:0]);
          if (op != 4'd7) m_acc = t[7:0];
        end
        4'd4: begin m_acc = m_acc & b; m_cy = 0; m_ac = 0; set_szp(m_acc); end
        4'd5: begin m_acc = m_acc ^ b; m_cy = 0; m_ac = 0; set_szp(m_acc); end
        4'd6: begin m_acc = m_acc | b; m_cy = 0; m_ac = 0; set_szp(m_acc); end
        4'd8: begin m_cy = m_acc[7]; m_acc = {m_acc[6:0], m_acc[7]}; end
        4'd9: begin m_cy = m_acc[0]; m_acc = {m_acc[0], m_acc[7:1]}; end
        4'd10: begin c = m_cy; m_cy = m_acc[7]; m_acc = {m_acc[6:0], c}; end
        4'd11: begin c = m_cy; m_cy = m_acc[0]; m_acc = {c, m_acc[7:1]}; end
        4'd12: begin m_ac = (r[3:0] == 4'hF); set_szp(u); end
        4'd13: begin m_ac = (r[3:0] == 4'h0); set_szp(u); end
        default: ;
      endcase
    end
    q_val.push_back({m_acc, mpack()});
    q_tag.push_back(tag);
  endtask

  // Monitor: compare after each active edge
  always @(posedge clk) begin
    logic [15:0] e;
    string       tg;
    #2;
    if (q_val.size() > 0) begin
      e  = q_val.pop_front();
      tg = q_tag.pop_front();
      check8({tg, " acc"}, acc, e[15:8]);
      check8({tg, " flags"}, flags, e[7:0]);
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    rst_n = 1'b0; op_strobe = 1'b0; op_code = 4'd0; operand = 8'd0; reg_byte = 8'd0;
    m_acc = 8'd0; m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
    repeat (3) @(negedge clk);
    check8("R1 acc in reset", acc, 8'h00);
    check8("R1 flags in reset", flags, 8'h02);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check8("R1 acc after release", acc, 8'h00);
    check8("R1 flags after release / R10 layout", flags, 8'h02);

    issue(4'd4, 8'h00, 8'h10, 1, "R5 AND zero");
    issue(4'd6, 8'h3A, 8'h10, 1, "R5 OR load");
    issue(4'd0, 8'h0C, 8'h10, 1, "R2 ADD half carry");
    issue(4'd0, 8'hBA, 8'h10, 1, "R2 ADD wrap to zero R6");
    issue(4'd1, 8'h00, 8'h10, 1, "R2 ADC carry in");
    issue(4'd2, 8'h02, 8'h10, 1, "R3 SUB underflow");
    issue(4'd3, 8'h0F, 8'h10, 1, "R3 SBB nibble borrow");
    issue(4'd7, 8'hEF, 8'h10, 1, "R4 CMP equal");
    issue(4'd7, 8'hF0, 8'h10, 1, "R4 CMP less");
    issue(4'd5, 8'hFF, 8'h10, 1, "R5 XOR");
    issue(4'd6, 8'h81, 8'h10, 1, "R5 OR sign R6");
    issue(4'd8, 8'h00, 8'h10, 1, "R7 RLC");
    issue(4'd10, 8'h00, 8'h10, 1, "R7 RAL");
    issue(4'd9, 8'h00, 8'h10, 1, "R7 RRC");
    issue(4'd11, 8'h00, 8'h10, 1, "R7 RAR");
    issue(4'd11, 8'h00, 8'h10, 1, "R7 RAR again");
    issue(4'd0, 8'hFF, 8'h10, 1, "R2 set carry");
    issue(4'd12, 8'h00, 8'hFF, 1, "R9 INC FF keeps CY");
    issue(4'd13, 8'h00, 8'h00, 1, "R9 DEC 00");
    issue(4'd13, 8'h00, 8'h50, 1, "R9 DEC 50");
    issue(4'd12, 8'h00, 8'h3E, 1, "R9 INC 3E");
    issue(4'd0, 8'h55, 8'h07, 0, "R11 strobe low");
    issue(4'd14, 8'h55, 8'h07, 1, "R11 opcode 14");
    issue(4'd15, 8'h55, 8'h07, 1, "R11 opcode 15");
    issue(4'd12, 8'h00, 8'h07, 0, "R11 INC strobe low");

    lfsr = 8'hA5;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      issue(lfsr[3:0], {lfsr[2:0], lfsr[7:3]} ^ 8'h3C, lfsr ^ 8'h96, lfsr[6] | lfsr[1],
            "R2 R3 R6 R7 R9 random");
    end

    @(negedge clk);
    op_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check8("R10 fixed bits", flags & 8'h2A, 8'h02);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule